// File: doc/BRIEF.md
# Binary64 Rounding and Packing Stage

This stage takes the end of a double-precision arithmetic datapath and turns it into a finished binary64 word. Its inputs are a sign, a signed unbiased exponent and a 56-bit significand. The significand is laid out from the top down as the hidden bit (bit 55, set on entry), 52 fraction bits and three guard/round/sticky bits (bits 2:0). From these the stage rounds, handles results too small to be normal, saturates results too large to be finite, and packs the sign, the biased exponent and the fraction. The same result cycle also reports whether the result was inexact, overflowed or underflowed. All three flags describe only that result; none of them accumulates.

A 2-bit mode input selects one of four roundings, and a flush input turns results below the normal range into zero or the smallest denormal. A valid/ready pair accepts one operand per cycle. The packed word appears one cycle after acceptance and stays on the outputs until the consumer takes it. NaN, infinity and exact-zero operands are never presented.

Top module: `dp_round_pack`

## Requirements
- R1: The block accepts an operand when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever no result is held or the held result is being taken. The result is valid on the next cycle and stays unchanged while `out_ready` is low.
- R2: The mode encoding is 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. The increment applies only when bits 2:0 are nonzero. For nearest-even the increment is 3 plus significand bit 3. Toward zero adds nothing. Toward +infinity adds 8 to positive values only, and toward -infinity adds 8 to negative values only. The three low bits are then dropped.
- R3: An in-range operand whose bits 2:0 are zero is packed unchanged, with all three flags low.
- R4: When rounding carries above the hidden bit, the significand is halved and the exponent goes up by one.
- R5: An exponent above 1023 after rounding raises overflow and inexact. The word is infinity for nearest-even; the largest finite magnitude for toward zero; infinity for toward +infinity on positive values and toward -infinity on negative values; and the largest finite magnitude for the other directed case.
- R6: With flush set, an exponent below -1022 raises underflow and inexact. The word is a signed zero, except that it is the smallest denormal of the operand's sign when the mode rounds away from zero for that sign (mode 2 positive, mode 3 negative).
- R7: Without flush, an exponent of exactly -1023 whose rounded significand carries out becomes the smallest normal (exponent field 1, fraction 0). It raises inexact but not underflow.
- R8: Otherwise, an exponent below -1022 shifts the significand right by the difference, ORs every lost bit into bit 0, and takes exponent -1022. A result with the hidden bit clear is packed with exponent field 0. Underflow is raised only when such a result is inexact.
- R9: A result with the hidden bit set is packed with exponent field = exponent + 1023 and the hidden bit dropped.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: The flush input has no effect on operands whose exponent is -1022 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Stage can accept an operand |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 13 | Signed unbiased exponent |
| in_sig | input | 56 | Hidden bit, fraction, three rounding bits |
| in_rmode | input | 2 | Rounding mode (0 nearest-even, 1 zero, 2 up, 3 down) |
| in_flush | input | 1 | Replace sub-normal-range results by zero/minimum |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 64 | Packed binary64 result |
| out_ovf | output | 1 | Overflow for this result |
| out_unf | output | 1 | Underflow for this result |
| out_inx | output | 1 | Inexact for this result |

## Verification
The rounding carry and the overflow decision can fall in the same cycle. An exponent of 1023 with an all-ones significand rounded to nearest carries into exponent 1024, so the expected word is infinity with overflow and inexact. The same operand rounded toward zero must instead give the largest finite value with only inexact. Likewise, the carry out of the boundary rounder at exponent -1023 meets the denormal shift. The bench judges these by comparing the full word and the flag triple from its scoreboard while the consumer throttles `out_ready`, so held results and back-to-back acceptance are exercised too.

// File: rtl/dprp_pkg.sv
package dprp_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  localparam int GRS_W = 3;
endpackage

// File: rtl/dprp_round.sv
module dprp_round #(
  parameter int SIG_W = 56
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             sign,
  input  logic [1:0]       rmode,
  output logic [SIG_W:0]   rsum,
  output logic             inexact
);
  import dprp_pkg::*;

  rmode_e         rm;
  logic [SIG_W:0] inc;

  assign rm = rmode_e'(rmode);

  always_comb begin
    inexact = |sig[GRS_W-1:0];
    inc     = '0;
    if (inexact) begin
      case (rm)
        RM_NEAR: inc = (SIG_W+1)'(3) + (SIG_W+1)'(sig[GRS_W]);
        RM_ZERO: inc = '0;
        RM_UP:   inc = sign ? '0 : (SIG_W+1)'(8);
        RM_DOWN: inc = sign ? (SIG_W+1)'(8) : '0;
        default: inc = '0;
      endcase
    end
    rsum = {1'b0, sig} + inc;
  end
endmodule

// File: rtl/dprp_sticky_shr.sv
module dprp_sticky_shr #(
  parameter int SIG_W = 56,
  parameter int SH_W  = $clog2(SIG_W + 1)
) (
  input  logic [SIG_W-1:0] val,
  input  logic [SH_W-1:0]  amt,
  output logic [SIG_W-1:0] res
);
  logic [SIG_W-1:0] lost_mask;
  logic             sticky;

  always_comb begin
    lost_mask = ~({SIG_W{1'b1}} << amt);
    sticky    = |(val & lost_mask);
    res       = val >> amt;
    res[0]    = res[0] | sticky;
  end
endmodule

// File: rtl/dprp_special.sv
module dprp_special #(
  parameter int FRAC_W = 52,
  parameter int EXPF_W = 11,
  localparam int W     = 1 + EXPF_W + FRAC_W
) (
  input  logic         sign,
  input  logic [1:0]   rmode,
  input  logic         sel_ovf,
  output logic [W-1:0] word
);
  import dprp_pkg::*;

  rmode_e rm;
  logic   away;

  assign rm = rmode_e'(rmode);

  always_comb begin
    away = ((rm == RM_UP) && !sign) || ((rm == RM_DOWN) && sign);
    if (sel_ovf) begin
      if (away || (rm == RM_NEAR))
        word = {sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      else
        word = {sign, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else begin
      if (away)
        word = {sign, {EXPF_W{1'b0}}, {(FRAC_W-1){1'b0}}, 1'b1};
      else
        word = {sign, {(W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack #(
  parameter int FRAC_W      = 52,
  parameter int EXPF_W      = 11,
  parameter int XE_W        = 13,
  parameter int SYNC_STAGES = 2,
  localparam int GRS_W      = dprp_pkg::GRS_W,
  localparam int SIG_W      = FRAC_W + 1 + GRS_W,
  localparam int W          = 1 + EXPF_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sign,
  input  logic [XE_W-1:0]   in_exp,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic [1:0]        in_rmode,
  input  logic              in_flush,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_word,
  output logic              out_ovf,
  output logic              out_unf,
  output logic              out_inx
);
  localparam int BIAS = (1 << (EXPF_W - 1)) - 1;
  localparam int EMIN = 1 - BIAS;
  localparam int EMAX = BIAS;
  localparam int WX   = XE_W + 2;
  localparam int SH_W = $clog2(SIG_W + 1);
  localparam logic signed [WX-1:0] EMIN_X = WX'(EMIN);
  localparam logic signed [WX-1:0] EMAX_X = WX'(EMAX);

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync = rst_pipe[SYNC_STAGES-1];

  // exponent range decisions
  logic signed [WX-1:0] xe0, xe1, xe2, es_full;
  logic                 below, at_edge;
  logic [SH_W-1:0]      es;

  always_comb begin
    xe0     = {{(WX-XE_W){in_exp[XE_W-1]}}, in_exp};
    below   = xe0 < EMIN_X;
    at_edge = xe0 == (EMIN_X - WX'(1));
    es_full = EMIN_X - xe0;
    es      = (es_full > WX'(SIG_W)) ? SH_W'(SIG_W) : SH_W'(es_full);
  end

  // boundary rounder (tininess after rounding) and denormal aligner
  logic [SIG_W:0]   rsum_edge;
  logic             inx_edge;
  logic [SIG_W-1:0] sig_shr;

  dprp_round #(.SIG_W(SIG_W)) u_rnd_edge (
    .sig(in_sig), .sign(in_sign), .rmode(in_rmode),
    .rsum(rsum_edge), .inexact(inx_edge)
  );

  dprp_sticky_shr #(.SIG_W(SIG_W), .SH_W(SH_W)) u_shr (
    .val(in_sig), .amt(es), .res(sig_shr)
  );

  logic [SIG_W-1:0] xm1;
  logic             edge_up;

  always_comb begin
    edge_up = 1'b0;
    xm1     = in_sig;
    xe1     = xe0;
    if (below && !in_flush) begin
      xe1 = EMIN_X;
      if (at_edge && rsum_edge[SIG_W]) begin
        edge_up = 1'b1;
        xm1     = SIG_W'(rsum_edge >> 1) & ~SIG_W'((1 << GRS_W) - 1);
      end else begin
        xm1     = sig_shr;
      end
    end
  end

  // main rounder
  logic [SIG_W:0]   rsum_main;
  logic             inx_main;
  logic [SIG_W-1:0] xm2;
  logic [FRAC_W:0]  mant;
  logic             unf_main;

  dprp_round #(.SIG_W(SIG_W)) u_rnd_main (
    .sig(xm1), .sign(in_sign), .rmode(in_rmode),
    .rsum(rsum_main), .inexact(inx_main)
  );

  always_comb begin
    unf_main = inx_main && !xm1[SIG_W-1];
    if (rsum_main[SIG_W]) begin
      xm2 = SIG_W'(rsum_main >> 1);
      xe2 = xe1 + WX'(1);
    end else begin
      xm2 = SIG_W'(rsum_main);
      xe2 = xe1;
    end
    mant = (FRAC_W+1)'(xm2 >> GRS_W);
  end

  // saturated / flushed values
  logic         flush_hit, ovf_hit;
  logic [W-1:0] special_word;

  assign flush_hit = below && in_flush;
  assign ovf_hit   = !flush_hit && (xe2 > EMAX_X);

  dprp_special #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W)) u_special (
    .sign(in_sign), .rmode(in_rmode), .sel_ovf(!flush_hit),
    .word(special_word)
  );

  // result selection
  logic [W-1:0]      word_d;
  logic              ovf_d, unf_d, inx_d;
  logic [EXPF_W-1:0] biased;

  always_comb begin
    biased = EXPF_W'(xe2 + WX'(BIAS));
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    inx_d  = 1'b0;
    if (flush_hit) begin
      word_d = special_word;
      unf_d  = 1'b1;
      inx_d  = 1'b1;
    end else if (ovf_hit) begin
      word_d = special_word;
      ovf_d  = 1'b1;
      inx_d  = 1'b1;
    end else begin
      inx_d  = (edge_up && inx_edge) || inx_main;
      unf_d  = unf_main;
      if (mant[FRAC_W]) word_d = {in_sign, biased, mant[FRAC_W-1:0]};
      else              word_d = {in_sign, {EXPF_W{1'b0}}, mant[FRAC_W-1:0]};
    end
  end

  // output stage with handshake
  logic load, valid_d;

  always_comb begin
    in_ready = rst_sync && (!out_valid || out_ready);
    load     = in_valid && in_ready;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_word <= word_d;
      out_ovf  <= ovf_d;
      out_unf  <= unf_d;
      out_inx  <= inx_d;
    end
  end

  // checks
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_word) && $stable(out_inx) && $stable(out_ovf) && $stable(out_unf)));

  assert_ovf_inexact_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && out_ovf) |-> (out_inx && !out_unf));

  assert_ovf_word_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && out_ovf) |->
      ((&out_word[W-2 -: EXPF_W]) ? (out_word[FRAC_W-1:0] == '0) : (&out_word[FRAC_W-1:0])));

  assert_unf_range_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && out_unf) |-> (out_inx && (out_word[W-2 -: EXPF_W] <= EXPF_W'(1))));

  assert_exact_quiet_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && !out_inx) |-> (!out_ovf && !out_unf));
endmodule

// File: tb/dp_round_pack_bench.sv
`timescale 1ns/1ps
module dp_round_pack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [12:0] in_exp = '0;
  logic [55:0] in_sig = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_flush = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_word;
  logic        out_ovf, out_unf, out_inx;

  always #5 clk = ~clk;

  dp_round_pack u_dp_round_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_rmode(in_rmode),
    .in_flush(in_flush), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx)
  );

  typedef struct {
    logic [63:0] word;
    logic [2:0]  flags;   // {ovf, unf, inx}
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   stall_mode = 1'b0;
  bit   done = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  localparam logic [55:0] H    = 56'h80000000000000;
  localparam logic [55:0] ONES = 56'hFFFFFFFFFFFFFF;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] PMAX = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] NMAX = 64'hFFEFFFFFFFFFFFFF;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // consumer throttle, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  // monitor: compare at the falling edge before the transfer edge
  logic [63:0] held_word;
  bit          held = 1'b0;
  always @(negedge clk) begin
    if (held && out_valid)
      check(out_word === held_word, "R1", "held word changed", out_word, held_word);
    held = 1'b0;
    if (out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1", "unexpected result", out_word, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_word === e.word, e.tag, "word", out_word, e.word);
        check({out_ovf, out_unf, out_inx} === e.flags, e.tag, "flags {ovf,unf,inx}",
              64'({out_ovf, out_unf, out_inx}), 64'(e.flags));
      end
    end else if (out_valid) begin
      held      = 1'b1;
      held_word = out_word;
    end
  end

  // driver: called at a falling edge, returns at a falling edge
  task automatic send(input bit s, input int e, input logic [55:0] sig,
                      input logic [1:0] rm, input bit fl,
                      input logic [63:0] w, input logic [2:0] fx, input string tag);
    exp_t item;
    in_sign  = s;
    in_exp   = 13'(e);
    in_sig   = sig;
    in_rmode = rm;
    in_flush = fl;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    item.word  = w;
    item.flags = fx;
    item.tag   = tag;
    sb.push_back(item);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready === 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);

    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      // R3 / R9: exact normals
      send(0, 0,    H,          2'd0, 0, 64'h3FF0000000000000, 3'b000, "R3");
      send(0, 1,    H | 56'h8,  2'd0, 0, 64'h4000000000000001, 3'b000, "R9");
      send(0, 1023, H,          2'd0, 0, 64'h7FE0000000000000, 3'b000, "R9");
      send(1, -1022, H,         2'd1, 0, 64'h8010000000000000, 3'b000, "R9");
      // R2: each mode
      send(0, 0, H | 56'h4,     2'd0, 0, 64'h3FF0000000000000, 3'b001, "R2");
      send(0, 0, H | 56'hC,     2'd0, 0, 64'h3FF0000000000002, 3'b001, "R2");
      send(0, 0, H | 56'h3,     2'd0, 0, 64'h3FF0000000000000, 3'b001, "R2");
      send(0, 0, H | 56'h5,     2'd0, 0, 64'h3FF0000000000001, 3'b001, "R2");
      send(0, 0, H | 56'h7,     2'd1, 0, 64'h3FF0000000000000, 3'b001, "R2");
      send(0, 0, H | 56'h1,     2'd2, 0, 64'h3FF0000000000001, 3'b001, "R2");
      send(1, 0, H | 56'h1,     2'd2, 0, 64'hBFF0000000000000, 3'b001, "R2");
      send(1, 0, H | 56'h1,     2'd3, 0, 64'hBFF0000000000001, 3'b001, "R2");
      send(0, 0, H | 56'h1,     2'd3, 0, 64'h3FF0000000000000, 3'b001, "R2");
      // R4: carry out of rounding
      send(0, 0, ONES,          2'd0, 0, 64'h4000000000000000, 3'b001, "R4");
      // R5: overflow per mode, and carry into overflow
      send(0, 1024, H, 2'd0, 0, PINF, 3'b101, "R5");
      send(1, 1024, H, 2'd0, 0, NINF, 3'b101, "R5");
      send(0, 1024, H, 2'd1, 0, PMAX, 3'b101, "R5");
      send(0, 1024, H, 2'd2, 0, PINF, 3'b101, "R5");
      send(1, 1024, H, 2'd2, 0, NMAX, 3'b101, "R5");
      send(0, 1024, H, 2'd3, 0, PMAX, 3'b101, "R5");
      send(1, 1024, H, 2'd3, 0, NINF, 3'b101, "R5");
      send(0, 1023, ONES, 2'd0, 0, PINF, 3'b101, "R5");
      send(0, 1023, ONES, 2'd1, 0, PMAX, 3'b001, "R5");
      // R6: flush per mode
      send(0, -1023, H, 2'd0, 1, 64'h0000000000000000, 3'b011, "R6");
      send(1, -1023, H, 2'd1, 1, 64'h8000000000000000, 3'b011, "R6");
      send(0, -1500, H, 2'd2, 1, 64'h0000000000000001, 3'b011, "R6");
      send(1, -1023, H, 2'd2, 1, 64'h8000000000000000, 3'b011, "R6");
      send(0, -1023, H, 2'd3, 1, 64'h0000000000000000, 3'b011, "R6");
      send(1, -1100, H, 2'd3, 1, 64'h8000000000000001, 3'b011, "R6");
      // R7: boundary exponent rounding up to the smallest normal
      send(0, -1023, ONES, 2'd0, 0, 64'h0010000000000000, 3'b001, "R7");
      send(0, -1023, ONES, 2'd1, 0, 64'h000FFFFFFFFFFFFF, 3'b011, "R7");
      // R8: denormals with sticky shift
      send(0, -1023, H,      2'd0, 0, 64'h0008000000000000, 3'b000, "R8");
      send(0, -1074, H,      2'd0, 0, 64'h0000000000000001, 3'b000, "R8");
      send(0, -1075, H | 56'h1, 2'd0, 0, 64'h0000000000000001, 3'b011, "R8");
      send(0, -1075, H | 56'h1, 2'd1, 0, 64'h0000000000000000, 3'b011, "R8");
      send(0, -2000, H,      2'd2, 0, 64'h0000000000000001, 3'b011, "R8");
      send(0, -2000, H,      2'd3, 0, 64'h0000000000000000, 3'b011, "R8");
      send(1, -1024, ONES,   2'd0, 0, 64'h8008000000000000, 3'b011, "R8");
      // R11: flush ignored in range
      send(0, 0,     H | 56'h5, 2'd0, 1, 64'h3FF0000000000001, 3'b001, "R11");
      send(1, -1022, H,         2'd0, 1, 64'h8010000000000000, 3'b000, "R11");
    end

    stall_mode = 1'b0;
    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R1", "results outstanding", 64'(sb.size()), 64'd0);
    done = 1'b1;
    finish_run();
  end
endmodule